// File: doc/BRIEF.md
# Self-Correcting Triple-Redundant Configuration Store

This block holds a small set of configuration words. Every stored bit exists in three separate copies, named A, B and C. The value seen on the read port is the 2-of-3 majority of those copies. A host writes a word by giving a row address, a data word and a load strobe. The load strobe is split into three lines, one per copy, and each copy has its own row decoder. A glitch on a single strobe line can therefore change only the copy that line belongs to.

A background scrubber steps through the rows, either every cycle or once per programmable interval. When the three copies of the current row disagree, the scrubber writes the voted value back into all three copies. It also sets a sticky flag for that row and bumps a saturating repair counter. A latent single-copy upset is in this way removed even in a row that is never read. An injection port can flip any single copy bit, so a bench can exercise the repair path. The default size is 32 rows of 16 bits, which gives 512 configuration bits.

Top module: `tmr_cfg_store`

## Requirements
- R1: A synchronous active-low reset clears all three copies of every row to zero, clears all row flags, clears the repair counter and returns the scrub row to 0.
- R2: When all three load lines are high, the data word is stored into all three copies of the addressed row at that clock edge. From the next cycle, reading that row returns the word, and no other row changes.
- R3: A load line that is high on its own (bit 0 = copy A, bit 1 = copy B, bit 2 = copy C) changes only that copy of the addressed row. The voted read value of that row stays as it was.
- R4: The read port is combinational. `rd_data` is the bitwise 2-of-3 majority of the three copies of row `rd_addr` in the same cycle.
- R5: The scrub row advances by one on each scrub tick and wraps from the last row to 0. A tick occurs once every `scrub_interval`+1 cycles, so a value of 0 means every cycle.
- R6: On a tick where the copies of the scrub row disagree, the voted value is written into all three copies at that edge. At the same edge, the row's flag in `fix_flags` (bit n = row n) is set and stays set until reset, and `fix_count` rises by exactly one.
- R7: `fix_count` saturates at its all-ones value (255 at the default width) and does not wrap.
- R8: If any load line targets the scrub row in a cycle where a repair of that row would happen, the host write is applied and the repair is dropped. In that case no flag is set and the counter is unchanged.
- R9: When `inj_en` is high, exactly one bit of one copy is inverted at that edge. The bit is given by `inj_bit`, the row by `inj_row` and the copy by `inj_copy` (0 = A, 1 = B, 2 = C). The voted read is unchanged. A later scrub of the row repairs the copy, so a second flip of the same bit in another copy also leaves the read value unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_load | input | 3 | Per-copy load strobes (bit 0 A, bit 1 B, bit 2 C) |
| wr_addr | input | 5 | Write row address |
| wr_data | input | 16 | Write data word |
| rd_addr | input | 5 | Read row address |
| rd_data | output | 16 | Majority-voted word of row rd_addr |
| inj_en | input | 1 | Flip one stored copy bit this cycle |
| inj_row | input | 5 | Row of the bit to flip |
| inj_bit | input | 4 | Bit position to flip |
| inj_copy | input | 2 | Copy to flip (0 A, 1 B, 2 C) |
| scrub_interval | input | 8 | Extra cycles between scrub steps |
| scrub_row | output | 5 | Row the scrubber examines this cycle |
| fix_flags | output | 32 | Sticky per-row repair flags |
| fix_count | output | 8 | Saturating repair counter |

## Verification
The read port is combinational, so a stored word is checked in the cycle that follows its write edge. The bench drives inputs at a falling edge and samples the outputs just after the next falling edge. A repair is due at the first tick on which the scrub row equals the damaged row. The bench either waits for more than one full sweep (34 cycles at interval 0) before it reads the counter and flags, or it aims an injection at the row just ahead of the pointer, which gives exactly one repair per cycle. The interval is measured as the number of cycles between changes of `scrub_row`, and the first change after a new interval is set is discarded because the interval counter may start anywhere.

// File: rtl/cfgtmr_pkg.sv
// Shared constants and types of the triple-redundant configuration store.
// Assumes exactly three copies; the voters are written for three inputs.
package cfgtmr_pkg;

    localparam int unsigned COPIES    = 3;
    localparam int unsigned DEF_ROWS  = 32;
    localparam int unsigned DEF_WIDTH = 16;
    localparam int unsigned DEF_CNT_W = 8;
    localparam int unsigned DEF_IVL_W = 8;

    // Copy index as carried on the injection port; CP_NONE selects nothing.
    typedef enum logic [1:0] {
        CP_A    = 2'd0,
        CP_B    = 2'd1,
        CP_C    = 2'd2,
        CP_NONE = 2'd3
    } copy_e;

endpackage

// File: rtl/cfg_row_decode.sv
// One-hot row decoder with an enable.
// Assumes ROWS does not exceed 2**AW; an address beyond ROWS-1 selects no row.
module cfg_row_decode #(
    parameter int unsigned ROWS = 32,
    parameter int unsigned AW   = $clog2(ROWS)
) (
    input  logic            en,
    input  logic [AW-1:0]   addr,
    output logic [ROWS-1:0] sel
);

    // one select line per row, high only when enabled and addressed
    for (genvar r = 0; r < ROWS; r++) begin : g_row
        assign sel[r] = en && (addr == AW'(r));
    end

endmodule

// File: rtl/cfg_voter.sv
// Bitwise 2-of-3 majority voter with a disagreement flag.
// Assumes at most one copy per bit is wrong; with two wrong copies the
// majority follows the wrong pair.
module cfg_voter #(
    parameter int unsigned WIDTH = 16
) (
    input  logic [WIDTH-1:0] cp_a,
    input  logic [WIDTH-1:0] cp_b,
    input  logic [WIDTH-1:0] cp_c,
    output logic [WIDTH-1:0] voted,
    output logic             differ
);

    // majority per bit, and whether any bit has a dissenting copy
    always_comb begin
        voted  = (cp_a & cp_b) | (cp_a & cp_c) | (cp_b & cp_c);
        differ = |((cp_a ^ cp_b) | (cp_a ^ cp_c));
    end

endmodule

// File: rtl/cfg_tmr_bank.sv
// Storage of all copies of all rows, with two read taps per copy.
// Each copy/row register has its own load select, so a strobe that reaches
// one copy cannot disturb another. The update priority is host load, then
// scrub repair, then fault injection.
module cfg_tmr_bank #(
    parameter int unsigned ROWS   = 32,
    parameter int unsigned WIDTH  = 16,
    parameter int unsigned COPIES = 3,
    parameter int unsigned AW     = $clog2(ROWS)
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [COPIES-1:0][ROWS-1:0]    load_sel,
    input  logic [WIDTH-1:0]               wr_data,
    input  logic [ROWS-1:0]                fix_sel,
    input  logic [WIDTH-1:0]               fix_data,
    input  logic [ROWS-1:0]                inj_row_sel,
    input  logic [COPIES-1:0]              inj_copy_sel,
    input  logic [WIDTH-1:0]               inj_mask,
    input  logic [AW-1:0]                  rd_row,
    input  logic [AW-1:0]                  sc_row,
    output logic [COPIES-1:0][WIDTH-1:0]   rd_word,
    output logic [COPIES-1:0][WIDTH-1:0]   sc_word
);

    logic [COPIES-1:0][ROWS-1:0][WIDTH-1:0] cells;

    for (genvar c = 0; c < COPIES; c++) begin : g_copy
        for (genvar r = 0; r < ROWS; r++) begin : g_row
            logic [WIDTH-1:0] q;

            // one copy of one row: reset, load, repair or flip
            always_ff @(posedge clk) begin
                if (!rst_n)
                    q <= '0;
                else if (load_sel[c][r])
                    q <= wr_data;
                else if (fix_sel[r])
                    q <= fix_data;
                else if (inj_row_sel[r] && inj_copy_sel[c])
                    q <= q ^ inj_mask;
            end

            assign cells[c][r] = q;
        end

        // read taps of this copy for the host port and the scrubber
        assign rd_word[c] = cells[c][rd_row];
        assign sc_word[c] = cells[c][sc_row];
    end

endmodule

// File: rtl/cfg_scrubber.sv
// Background scrub sequencer: paces the row pointer, decides when a row is
// repaired, and keeps the sticky row flags and the saturating counter.
// Assumes row_bad and host_hit describe the row on `row` in this cycle.
module cfg_scrubber #(
    parameter int unsigned ROWS  = 32,
    parameter int unsigned AW    = $clog2(ROWS),
    parameter int unsigned IVL_W = 8,
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IVL_W-1:0] interval,
    input  logic             row_bad,
    input  logic             host_hit,
    output logic [AW-1:0]    row,
    output logic             fix_en,
    output logic [ROWS-1:0]  flags,
    output logic [CNT_W-1:0] count
);

    localparam logic [AW-1:0]    LAST_ROW = AW'(ROWS - 1);
    localparam logic [CNT_W-1:0] CNT_MAX  = '1;

    logic [IVL_W-1:0] wait_cnt;
    logic             tick;

    // a step is due once the wait counter has reached the interval
    always_comb begin
        tick   = (wait_cnt >= interval);
        fix_en = tick && row_bad && !host_hit;
    end

    // wait counter between scrub steps
    always_ff @(posedge clk) begin
        if (!rst_n || tick)
            wait_cnt <= '0;
        else
            wait_cnt <= wait_cnt + 1'b1;
    end

    // row pointer, wrapping after the last row
    always_ff @(posedge clk) begin
        if (!rst_n)
            row <= '0;
        else if (tick)
            row <= (row == LAST_ROW) ? '0 : row + 1'b1;
    end

    // sticky repair flags, one per row
    always_ff @(posedge clk) begin
        if (!rst_n)
            flags <= '0;
        else if (fix_en)
            flags[row] <= 1'b1;
    end

    // repair counter that holds at its maximum
    always_ff @(posedge clk) begin
        if (!rst_n)
            count <= '0;
        else if (fix_en && (count != CNT_MAX))
            count <= count + 1'b1;
    end

endmodule

// File: rtl/tmr_cfg_store.sv
// Top of the self-correcting triple-redundant configuration store.
// Three independent load decoders, one read voter for the host and one
// voter for the scrubber. Injection flips one copy bit and is meant for test.
// Assumes synchronous inputs in the clk domain.
module tmr_cfg_store
    import cfgtmr_pkg::*;
#(
    parameter int unsigned ROWS  = DEF_ROWS,
    parameter int unsigned WIDTH = DEF_WIDTH,
    parameter int unsigned CNT_W = DEF_CNT_W,
    parameter int unsigned IVL_W = DEF_IVL_W,
    localparam int unsigned AW   = $clog2(ROWS),
    localparam int unsigned BW   = $clog2(WIDTH),
    localparam int unsigned NCP  = COPIES
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NCP-1:0]   wr_load,
    input  logic [AW-1:0]    wr_addr,
    input  logic [WIDTH-1:0] wr_data,
    input  logic [AW-1:0]    rd_addr,
    output logic [WIDTH-1:0] rd_data,
    input  logic             inj_en,
    input  logic [AW-1:0]    inj_row,
    input  logic [BW-1:0]    inj_bit,
    input  logic [1:0]       inj_copy,
    input  logic [IVL_W-1:0] scrub_interval,
    output logic [AW-1:0]    scrub_row,
    output logic [ROWS-1:0]  fix_flags,
    output logic [CNT_W-1:0] fix_count
);

    logic [NCP-1:0][ROWS-1:0]  load_sel;
    logic [ROWS-1:0]           fix_sel;
    logic [ROWS-1:0]           inj_row_sel;
    logic [NCP-1:0]            inj_copy_sel;
    logic [WIDTH-1:0]          inj_mask;
    logic [NCP-1:0][WIDTH-1:0] rd_word;
    logic [NCP-1:0][WIDTH-1:0] sc_word;
    logic [WIDTH-1:0]          sc_voted;
    logic                      sc_differ;
    logic                      rd_differ;
    logic                      fix_en;
    logic                      host_hit;
    copy_e                     inj_cp;

    // a separate decoder per copy keeps the three load paths apart
    for (genvar c = 0; c < NCP; c++) begin : g_load
        cfg_row_decode #(.ROWS(ROWS), .AW(AW)) u_dec (
            .en   (wr_load[c]),
            .addr (wr_addr),
            .sel  (load_sel[c])
        );
    end

    cfg_row_decode #(.ROWS(ROWS), .AW(AW)) u_inj_dec (
        .en   (inj_en),
        .addr (inj_row),
        .sel  (inj_row_sel)
    );

    cfg_row_decode #(.ROWS(ROWS), .AW(AW)) u_fix_dec (
        .en   (fix_en),
        .addr (scrub_row),
        .sel  (fix_sel)
    );

    assign inj_cp = copy_e'(inj_copy);

    // copy select and bit mask of the injection
    for (genvar c = 0; c < NCP; c++) begin : g_inj
        assign inj_copy_sel[c] = (inj_cp == copy_e'(c));
    end
    assign inj_mask = WIDTH'(1) << inj_bit;

    // any load line on the row being scrubbed takes priority over a repair
    assign host_hit = (|wr_load) && (wr_addr == scrub_row);

    cfg_tmr_bank #(.ROWS(ROWS), .WIDTH(WIDTH), .COPIES(NCP), .AW(AW)) u_bank (
        .clk          (clk),
        .rst_n        (rst_n),
        .load_sel     (load_sel),
        .wr_data      (wr_data),
        .fix_sel      (fix_sel),
        .fix_data     (sc_voted),
        .inj_row_sel  (inj_row_sel),
        .inj_copy_sel (inj_copy_sel),
        .inj_mask     (inj_mask),
        .rd_row       (rd_addr),
        .sc_row       (scrub_row),
        .rd_word      (rd_word),
        .sc_word      (sc_word)
    );

    cfg_voter #(.WIDTH(WIDTH)) u_rd_vote (
        .cp_a   (rd_word[0]),
        .cp_b   (rd_word[1]),
        .cp_c   (rd_word[2]),
        .voted  (rd_data),
        .differ (rd_differ)
    );

    cfg_voter #(.WIDTH(WIDTH)) u_sc_vote (
        .cp_a   (sc_word[0]),
        .cp_b   (sc_word[1]),
        .cp_c   (sc_word[2]),
        .voted  (sc_voted),
        .differ (sc_differ)
    );

    cfg_scrubber #(.ROWS(ROWS), .AW(AW), .IVL_W(IVL_W), .CNT_W(CNT_W)) u_scrub (
        .clk      (clk),
        .rst_n    (rst_n),
        .interval (scrub_interval),
        .row_bad  (sc_differ),
        .host_hit (host_hit),
        .row      (scrub_row),
        .fix_en   (fix_en),
        .flags    (fix_flags),
        .count    (fix_count)
    );

    // the host read mismatch is observed by the scrubber path only
    logic unused_rd_differ;
    assign unused_rd_differ = rd_differ;

endmodule

// File: rtl/cfg_store_chk.sv
// Property checker for tmr_cfg_store, attached with bind below.
// Observes ports only.
module cfg_store_chk #(
    parameter int unsigned ROWS  = 32,
    parameter int unsigned WIDTH = 16,
    parameter int unsigned CNT_W = 8,
    parameter int unsigned AW    = $clog2(ROWS)
) (
    input logic             clk,
    input logic             rst_n,
    input logic [2:0]       wr_load,
    input logic [AW-1:0]    wr_addr,
    input logic [WIDTH-1:0] wr_data,
    input logic [AW-1:0]    rd_addr,
    input logic [WIDTH-1:0] rd_data,
    input logic [AW-1:0]    scrub_row,
    input logic [ROWS-1:0]  fix_flags,
    input logic [CNT_W-1:0] fix_count
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [AW-1:0]    row_inc;
    logic [CNT_W-1:0] cnt_inc;
    assign row_inc = scrub_row + 1'b1;
    assign cnt_inc = fix_count + 1'b1;

    // R2
    full_write_visible_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((&wr_load) && (rd_addr == wr_addr)) |=>
        (!$stable(rd_addr) || (rd_data == $past(wr_data))));

    // R5
    scrub_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((scrub_row == $past(scrub_row)) || (scrub_row == $past(row_inc))));

    // R6
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fix_count != CNT_MAX) |=>
        ((fix_count == $past(fix_count)) || (fix_count == $past(cnt_inc))));

    // R6
    flags_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((fix_flags & $past(fix_flags)) == $past(fix_flags)));

    // R7
    count_saturate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fix_count == CNT_MAX) |=> (fix_count == CNT_MAX));

    // R8
    host_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((|wr_load) && (wr_addr == scrub_row)) |=> $stable(fix_count));

endmodule

bind tmr_cfg_store cfg_store_chk #(
    .ROWS  (ROWS),
    .WIDTH (WIDTH),
    .CNT_W (CNT_W),
    .AW    (AW)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_load   (wr_load),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .rd_addr   (rd_addr),
    .rd_data   (rd_data),
    .scrub_row (scrub_row),
    .fix_flags (fix_flags),
    .fix_count (fix_count)
);

// File: tb/sim_tmr_cfg_store.sv
// Self-checking bench for tmr_cfg_store at its default size.
// Inputs change at falling edges; outputs are sampled after falling edges.
module sim_tmr_cfg_store;

    localparam int ROWS  = 32;
    localparam int WIDTH = 16;
    localparam int CNT_W = 8;
    localparam int IVL_W = 8;
    localparam int AW    = 5;
    localparam int BW    = 4;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [2:0]       wr_load = '0;
    logic [AW-1:0]    wr_addr = '0;
    logic [WIDTH-1:0] wr_data = '0;
    logic [AW-1:0]    rd_addr = '0;
    logic [WIDTH-1:0] rd_data;
    logic             inj_en = 1'b0;
    logic [AW-1:0]    inj_row = '0;
    logic [BW-1:0]    inj_bit = '0;
    logic [1:0]       inj_copy = '0;
    logic [IVL_W-1:0] scrub_interval = '0;
    logic [AW-1:0]    scrub_row;
    logic [ROWS-1:0]  fix_flags;
    logic [CNT_W-1:0] fix_count;

    int n_cmp = 0;
    int n_bad = 0;
    logic [WIDTH-1:0] exp_row [ROWS];
    int exp_cnt = 0;
    logic [ROWS-1:0] exp_flags = '0;

    always #2.5 clk = ~clk;

    tmr_cfg_store #(.ROWS(ROWS), .WIDTH(WIDTH), .CNT_W(CNT_W), .IVL_W(IVL_W)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_load(wr_load), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .inj_en(inj_en), .inj_row(inj_row), .inj_bit(inj_bit), .inj_copy(inj_copy),
        .scrub_interval(scrub_interval), .scrub_row(scrub_row),
        .fix_flags(fix_flags), .fix_count(fix_count)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] expv);
        n_cmp++;
        if (act !== expv) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, expv);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    // called at a falling edge; holds the write for one rising edge
    task automatic host_write(input logic [2:0] ld, input int row, input logic [WIDTH-1:0] d);
        wr_load = ld; wr_addr = AW'(row); wr_data = d;
        @(negedge clk);
        wr_load = '0;
    endtask

    task automatic inject(input int row, input int bitpos, input int cp);
        inj_en = 1'b1; inj_row = AW'(row); inj_bit = BW'(bitpos); inj_copy = 2'(cp);
        @(negedge clk);
        inj_en = 1'b0;
    endtask

    task automatic read_row(input int row, output logic [WIDTH-1:0] v);
        rd_addr = AW'(row);
        #1;
        v = rd_data;
    endtask

    task automatic wait_row(input int row);
        while (scrub_row !== AW'(row)) @(negedge clk);
    endtask

    task automatic measure(output int n);
        logic [AW-1:0] prev;
        prev = scrub_row;
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (scrub_row == prev);
    endtask

    task automatic check_all_rows(input string tag);
        logic [WIDTH-1:0] v;
        for (int r = 0; r < ROWS; r++) begin
            read_row(r, v);
            chk($sformatf("%s row %0d", tag, r), 32'(v), 32'(exp_row[r]));
        end
    endtask

    task automatic chase(input int n);
        int p;
        for (int i = 0; i < n; i++) begin
            p = int'(scrub_row);
            inj_en = 1'b1;
            inj_row = AW'((p + 1) % ROWS);
            inj_bit = BW'((i >> 5) & 15);
            inj_copy = 2'((i >> 9) % 3);
            @(negedge clk);
        end
        inj_en = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        #(5.0 * 150000);
        n_bad++;
        $display("FAIL watchdog expired (all requirements) actual=running expected=done");
        summary();
        $finish;
    end

    initial begin
        logic [WIDTH-1:0] v;
        int n;

        for (int r = 0; r < ROWS; r++) exp_row[r] = '0;
        repeat (3) @(negedge clk);
        // R1: state while reset is held
        chk("R1 count", 32'(fix_count), 0);
        chk("R1 flags", 32'(fix_flags), 0);
        chk("R1 scrub row", 32'(scrub_row), 0);
        check_all_rows("R1 cleared");
        rst_n = 1'b1;
        @(negedge clk);

        // R2: full writes of every row, then read all back
        for (int r = 0; r < ROWS; r++) begin
            exp_row[r] = WIDTH'((r * 16'h1357) ^ 16'hA5C3);
            host_write(3'b111, r, exp_row[r]);
        end
        check_all_rows("R2 readback");
        chk("R2 no repairs", 32'(fix_count), 0);

        // R4 / R9: single flip is hidden by the vote, then repaired
        wait_row(7);
        inject(6, 4, 0);
        read_row(6, v);
        chk("R4 voted read after flip", 32'(v), 32'(exp_row[6]));
        chk("R9 not yet repaired", 32'(fix_count), 0);
        repeat (34) @(negedge clk);
        exp_cnt = 1; exp_flags[6] = 1'b1;
        chk("R9 count after repair", 32'(fix_count), 32'(exp_cnt));
        chk("R6 flag of row 6", 32'(fix_flags), 32'(exp_flags));
        inject(6, 4, 1);
        read_row(6, v);
        chk("R9 second copy flip hidden", 32'(v), 32'(exp_row[6]));
        repeat (34) @(negedge clk);
        exp_cnt = 2;
        chk("R9 count after second repair", 32'(fix_count), 32'(exp_cnt));

        // R3: each load line alone touches only its copy
        for (int c = 0; c < 3; c++) begin
            host_write(3'(1 << c), 9, ~exp_row[9]);
            read_row(9, v);
            chk($sformatf("R3 row 9 after lone load %0d", c), 32'(v), 32'(exp_row[9]));
            read_row(10, v);
            chk($sformatf("R3 row 10 after lone load %0d", c), 32'(v), 32'(exp_row[10]));
            repeat (34) @(negedge clk);
            exp_cnt++; exp_flags[9] = 1'b1;
            chk($sformatf("R6 count after lone load %0d", c), 32'(fix_count), 32'(exp_cnt));
        end
        chk("R6 flags rows 6 and 9", 32'(fix_flags), 32'(exp_flags));

        // R8: write on the row being repaired wins
        wait_row(21);
        inject(20, 3, 0);
        wait_row(20);
        exp_row[20] = 16'h5AF0;
        host_write(3'b111, 20, exp_row[20]);
        chk("R8 count unchanged", 32'(fix_count), 32'(exp_cnt));
        chk("R8 no flag", 32'(fix_flags), 32'(exp_flags));
        read_row(20, v);
        chk("R8 host data stored", 32'(v), 32'(exp_row[20]));
        repeat (34) @(negedge clk);
        chk("R8 nothing left to repair", 32'(fix_count), 32'(exp_cnt));

        // R5: pacing and wrap of the scrub row
        scrub_interval = 8'd3;
        measure(n);
        measure(n);
        chk("R5 interval 3", 32'(n), 4);
        scrub_interval = 8'd5;
        measure(n);
        measure(n);
        chk("R5 interval 5", 32'(n), 6);
        scrub_interval = 8'd0;
        measure(n);
        measure(n);
        chk("R5 interval 0", 32'(n), 1);
        wait_row(31);
        @(negedge clk);
        chk("R5 wrap to row 0", 32'(scrub_row), 0);

        // R6: one repair per cycle when chasing the pointer
        chase(20);
        exp_cnt += 20;
        chk("R6 twenty repairs", 32'(fix_count), 32'(exp_cnt));

        // R7 / R9: every row, bit and copy flipped once
        chase(ROWS * WIDTH * 3);
        chk("R7 saturated count", 32'(fix_count), 255);
        chk("R6 all flags", 32'(fix_flags), 32'hFFFF_FFFF);
        check_all_rows("R9 after sweep");
        repeat (3) @(negedge clk);
        chk("R7 holds", 32'(fix_count), 255);

        // R1: reset in mid-run
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        for (int r = 0; r < ROWS; r++) exp_row[r] = '0;
        chk("R1 count after reset", 32'(fix_count), 0);
        chk("R1 flags after reset", 32'(fix_flags), 0);
        check_all_rows("R1 rows after reset");

        summary();
        $finish;
    end

endmodule